// File: doc/BRIEF.md
# Load-Use Interlock Stall Controller

This block holds back a five-stage pipeline for one cycle when the instruction in decode needs a register that the load now in execute has not yet fetched from memory. A load's data appears only at the end of the memory stage, so the dependent instruction right behind it cannot be served by forwarding alone. On such a hazard the block deasserts the write enables of the program counter and of the fetch/decode register, so the fetch and decode stages hold still and no new instruction is fetched. It also injects a no-op into the execute stage for that cycle. Older instructions keep moving. One cycle later the loaded value can be forwarded from the memory/writeback register.

The block owns the control slice of the decode/execute pipeline register. This slice holds the register-write, memory-read and memory-write enables and the destination field. The hazard check therefore compares against its own execute-stage copy. A bubble clears every one of those enables and the destination field, which makes the injected slot a true no-op.

A store that depends on the load only through its data operand does not stall, because that value reaches the memory input through forwarding. A dependence through the store's base-address operand still stalls. Register 0, and source operands the instruction does not read, never cause a stall.

Top module: `lu_interlock`

## Requirements
- R1: While rst_ni is low, all execute-stage control outputs are 0, pc_we_o and ifid_we_o are 1, and idex_bubble_o is 0.
- R2: A stall is signalled (pc_we_o=0, ifid_we_o=0, idex_bubble_o=1) when the execute stage holds a load (ex_mem_re_o=1) with a nonzero destination, and the decode instruction reads its first source (id_use_rs1_i=1) with id_rs1_i equal to that destination.
- R3: A stall is likewise signalled when the second source is read (id_use_rs2_i=1), id_rs2_i matches the load's nonzero destination, and id_is_store_i=0.
- R4: A store (id_is_store_i=1) whose second source, the store data, is the only match against the load's destination causes no stall.
- R5: A store whose first source, the base address, matches the load's nonzero destination stalls.
- R6: A load destination of 0 never causes a stall.
- R7: A source field whose use flag is 0 never causes a stall, even if it matches.
- R8: An execute-stage instruction that is not a load (ex_mem_re_o=0) never causes a stall, even if it writes a matching register.
- R9: In the cycle after a stall, ex_reg_we_o, ex_mem_re_o and ex_mem_we_o are 0 and ex_rd_o is 0.
- R10: In the cycle after a non-stall cycle, the execute-stage outputs equal the decode-stage control inputs of the previous cycle.
- R11: A stall never lasts more than one cycle in a row.
- R12: pc_we_o and ifid_we_o are always equal, and both are the inverse of idex_bubble_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_rs1_i | input | 5 | Decode first source register (base address for stores) |
| id_rs2_i | input | 5 | Decode second source register (data for stores) |
| id_use_rs1_i | input | 1 | Decode instruction reads first source |
| id_use_rs2_i | input | 1 | Decode instruction reads second source |
| id_is_store_i | input | 1 | Decode instruction is a store |
| id_reg_we_i | input | 1 | Decode register-write enable |
| id_mem_re_i | input | 1 | Decode memory-read enable (load) |
| id_mem_we_i | input | 1 | Decode memory-write enable |
| id_rd_i | input | 5 | Decode destination register |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| idex_bubble_o | output | 1 | Inject a no-op into decode/execute |
| ex_reg_we_o | output | 1 | Execute-stage register-write enable |
| ex_mem_re_o | output | 1 | Execute-stage memory-read enable |
| ex_mem_we_o | output | 1 | Execute-stage memory-write enable |
| ex_rd_o | output | 5 | Execute-stage destination register |

## Verification
The hardest situation to reach from the ports is a dependent instruction that meets a load already sitting in execute. The execute state can only be loaded by driving a load through decode one cycle earlier, so every hazard takes a two-cycle setup. The store exemptions add a further condition on which operand matches. Directed pairs build each case in turn: the first-source match, the store-data match, the base-address match, destination 0 and unused operands. Random stimulus draws register numbers from a range of four values and makes loads frequent, so back-to-back load/use pairs and repeated stalls occur often. A bench model of the execute slice predicts every stall.

// File: rtl/lu_interlock_pkg.sv
package lu_interlock_pkg;
  typedef struct packed {
    logic reg_we;
    logic mem_re;
    logic mem_we;
  } stage_ctrl_t;

  localparam stage_ctrl_t CTRL_NOP = '{reg_we: 1'b0, mem_re: 1'b0, mem_we: 1'b0};
endpackage

// File: rtl/lu_src_match.sv
module lu_src_match #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic              used_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  output logic              hit_o
);
  // register 0 is hardwired, never a true dependence
  assign hit_o = used_i && (ex_rd_i != '0) && (src_i == ex_rd_i);
endmodule

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect #(
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] src_i,
  input  logic [NUM_SRC-1:0]             used_i,
  input  logic [NUM_SRC-1:0]             exempt_i,
  input  logic                           ex_load_i,
  input  logic [REG_AW-1:0]              ex_rd_i,
  output logic                           stall_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    lu_src_match #(.REG_AW(REG_AW)) i_match (
      .src_i  (src_i[g]),
      .used_i (used_i[g]),
      .ex_rd_i(ex_rd_i),
      .hit_o  (hit[g])
    );
  end

  assign stall_o = ex_load_i && |(hit & ~exempt_i);

  a_r6_rd_zero_no_stall : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rd_i == '0) |-> !stall_o);
  a_r7_unused_no_stall : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_i == '0) |-> !stall_o);
  a_r8_nonload_no_stall : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_load_i |-> !stall_o);
endmodule

// File: rtl/lu_idex_ctrl.sv
module lu_idex_ctrl
  import lu_interlock_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bubble_i,
  input  stage_ctrl_t       id_ctrl_i,
  input  logic [REG_AW-1:0] id_rd_i,
  output stage_ctrl_t       ex_ctrl_o,
  output logic [REG_AW-1:0] ex_rd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_ctrl_o <= CTRL_NOP;
      ex_rd_o   <= '0;
    end else if (bubble_i) begin
      ex_ctrl_o <= CTRL_NOP;
      ex_rd_o   <= '0;
    end else begin
      ex_ctrl_o <= id_ctrl_i;
      ex_rd_o   <= id_rd_i;
    end
  end

  a_r9_bubble_clears : assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_i |=> (ex_ctrl_o == CTRL_NOP) && (ex_rd_o == '0));
  a_r10_pass_through : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bubble_i |=> (ex_ctrl_o == $past(id_ctrl_i)) && (ex_rd_o == $past(id_rd_i)));
endmodule

// File: rtl/lu_interlock.sv
module lu_interlock
  import lu_interlock_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_use_rs1_i,
  input  logic              id_use_rs2_i,
  input  logic              id_is_store_i,
  input  logic              id_reg_we_i,
  input  logic              id_mem_re_i,
  input  logic              id_mem_we_i,
  input  logic [REG_AW-1:0] id_rd_i,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              idex_bubble_o,
  output logic              ex_reg_we_o,
  output logic              ex_mem_re_o,
  output logic              ex_mem_we_o,
  output logic [REG_AW-1:0] ex_rd_o
);
  localparam int unsigned NumSrc  = 2;
  localparam int unsigned DataIdx = 1;  // store data travels on the second source

  logic [NumSrc-1:0][REG_AW-1:0] src;
  logic [NumSrc-1:0]             used;
  logic [NumSrc-1:0]             exempt;
  logic                          stall;
  stage_ctrl_t                   id_ctrl;
  stage_ctrl_t                   ex_ctrl;

  assign src  = {id_rs2_i, id_rs1_i};
  assign used = {id_use_rs2_i, id_use_rs1_i};

  always_comb begin
    exempt          = '0;
    exempt[DataIdx] = id_is_store_i;  // forwarded into the memory stage instead
  end

  assign id_ctrl = '{reg_we: id_reg_we_i, mem_re: id_mem_re_i, mem_we: id_mem_we_i};

  lu_hazard_detect #(.REG_AW(REG_AW), .NUM_SRC(NumSrc)) i_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src),
    .used_i   (used),
    .exempt_i (exempt),
    .ex_load_i(ex_ctrl.mem_re),
    .ex_rd_i  (ex_rd_o),
    .stall_o  (stall)
  );

  lu_idex_ctrl #(.REG_AW(REG_AW)) i_idex (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bubble_i (stall),
    .id_ctrl_i(id_ctrl),
    .id_rd_i  (id_rd_i),
    .ex_ctrl_o(ex_ctrl),
    .ex_rd_o  (ex_rd_o)
  );

  assign pc_we_o       = !stall;
  assign ifid_we_o     = !stall;
  assign idex_bubble_o = stall;
  assign ex_reg_we_o   = ex_ctrl.reg_we;
  assign ex_mem_re_o   = ex_ctrl.mem_re;
  assign ex_mem_we_o   = ex_ctrl.mem_we;

  a_r11_single_stall : assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |=> !idex_bubble_o);
  a_r12_enables_agree : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_o == ifid_we_o) && (pc_we_o != idex_bubble_o));
  a_r4_store_data_exempt : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_is_store_i && !(id_use_rs1_i && id_rs1_i == ex_rd_o)) |-> !idex_bubble_o);
  a_r2_rs1_load_use : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_mem_re_o && ex_rd_o != '0 && id_use_rs1_i && id_rs1_i == ex_rd_o) |-> idex_bubble_o);
endmodule

// File: tb/test_lu_interlock.sv
module test_lu_interlock;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] rs1 = '0, rs2 = '0, rd = '0;
  logic          u1 = 1'b0, u2 = 1'b0, st = 1'b0, we = 1'b0, re = 1'b0, mwe = 1'b0;
  logic          pc_we, ifid_we, bubble, ex_we, ex_re, ex_mwe;
  logic [AW-1:0] ex_rd;

  logic          m_we = 1'b0, m_re = 1'b0, m_mwe = 1'b0, prev_stall = 1'b0;
  logic [AW-1:0] m_rd = '0;
  int            errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lu_interlock #(.REG_AW(AW)) i_lu_interlock (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs1_i(rs1), .id_rs2_i(rs2), .id_use_rs1_i(u1), .id_use_rs2_i(u2),
    .id_is_store_i(st), .id_reg_we_i(we), .id_mem_re_i(re), .id_mem_we_i(mwe),
    .id_rd_i(rd),
    .pc_we_o(pc_we), .ifid_we_o(ifid_we), .idex_bubble_o(bubble),
    .ex_reg_we_o(ex_we), .ex_mem_re_o(ex_re), .ex_mem_we_o(ex_mwe), .ex_rd_o(ex_rd)
  );

  function automatic logic exp_stall(logic [AW-1:0] a, logic [AW-1:0] b, logic ua, logic ub,
                                     logic s, logic eload, logic [AW-1:0] erd);
    logic h1, h2;
    h1 = ua && erd != 0 && a == erd;
    h2 = ub && erd != 0 && b == erd && !s;
    return eload && (h1 || h2);
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic drive(logic [AW-1:0] a, logic [AW-1:0] b, logic ua, logic ub, logic s,
                       logic w, logic r, logic mw, logic [AW-1:0] d, string tag);
    logic e;
    @(negedge clk);
    rs1 = a; rs2 = b; u1 = ua; u2 = ub; st = s; we = w; re = r; mwe = mw; rd = d;
    #1;
    e = exp_stall(a, b, ua, ub, s, m_re, m_rd);
    check(tag, bubble, e);
    check(tag, pc_we, !e);
    check("R12", ifid_we, pc_we);
    if (prev_stall) check("R11", bubble, 0);
    @(posedge clk);
    if (e) begin
      m_we = 0; m_re = 0; m_mwe = 0; m_rd = '0;
    end else begin
      m_we = w; m_re = r; m_mwe = mw; m_rd = d;
    end
    prev_stall = e;
    #1;
    check(e ? "R9" : "R10", {ex_we, ex_re, ex_mwe}, {m_we, m_re, m_mwe});
    check(e ? "R9" : "R10", ex_rd, m_rd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: state under reset
    repeat (3) @(posedge clk);
    #1;
    check("R1", {ex_we, ex_re, ex_mwe}, 0);
    check("R1", ex_rd, 0);
    check("R1", pc_we, 1);
    check("R1", ifid_we, 1);
    check("R1", bubble, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // load r3, then consumer on first source
    drive(0, 0, 0, 0, 0, 1, 1, 0, 3, "R10");
    drive(3, 9, 1, 0, 0, 1, 0, 0, 10, "R2");
    drive(3, 9, 1, 0, 0, 1, 0, 0, 10, "R11");
    // store data depends on load: exempt
    drive(0, 0, 0, 0, 0, 1, 1, 0, 4, "R10");
    drive(1, 4, 1, 1, 1, 0, 0, 1, 0, "R4");
    // store base depends on load: stall
    drive(0, 0, 0, 0, 0, 1, 1, 0, 5, "R10");
    drive(5, 2, 1, 1, 1, 0, 0, 1, 0, "R5");
    // store with both operands matching still stalls via base
    drive(0, 0, 0, 0, 0, 1, 1, 0, 6, "R10");
    drive(6, 6, 1, 1, 1, 0, 0, 1, 0, "R5");
    // destination 0
    drive(0, 0, 0, 0, 0, 1, 1, 0, 0, "R10");
    drive(0, 0, 1, 1, 0, 1, 0, 0, 1, "R6");
    // unused sources
    drive(0, 0, 0, 0, 0, 1, 1, 0, 6, "R10");
    drive(6, 6, 0, 0, 0, 1, 0, 0, 1, "R7");
    // second source, non-store
    drive(0, 0, 0, 0, 0, 1, 1, 0, 7, "R10");
    drive(2, 7, 1, 1, 0, 1, 0, 0, 8, "R3");
    // non-load producer
    drive(0, 0, 0, 0, 0, 1, 0, 0, 8, "R10");
    drive(8, 8, 1, 1, 0, 1, 0, 0, 9, "R8");

    for (int i = 0; i < 3000; i++) begin
      logic isld, isst;
      isld = ($urandom % 2) == 0;
      isst = !isld && ($urandom % 4) == 0;
      drive($urandom % 4, $urandom % 4, $urandom % 2, $urandom % 2, isst,
            !isst && ($urandom % 8 != 0), isld, isst, $urandom % 4, "R2");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule